// File: doc/BRIEF.md
# PIM Operating Mode Controller

This block sits on the command path of one memory channel and decides how the processing-in-memory device treats each command. It watches every command as it is issued (type, bank and row) and keeps a mode register with three states. In single-bank mode the device acts as plain memory. In all-bank mode one access reaches one bank in each even/odd bank pair, so one write fills the same location in every such bank. In all-bank-PIM mode every read or write also tells the processing units to execute their next instruction, and the external data path is switched off.

Mode changes use no new command type. The memory controller issues a fixed train of activate/precharge pairs to a reserved row. Each target mode has its own reserved row. A train that is interrupted, or that does not fit the current mode, leaves the mode alone. The new mode applies from the command after the final precharge.

Top module: `pim_mode_ctrl`

## Requirements
- R1: After reset the mode output reads 0 (single-bank), and `io_dis`, `bcast_en` and `exec_trig` are low.
- R2: In single-bank mode (code 0) any command other than NOP (code 0 on `cmd_type`) drives `bank_sel` one-hot at bit `cmd_bank`. `bcast_en` and `exec_trig` stay low. A NOP selects no bank.
- R3: A mode-change train is ACT (code 1) to bank 0 at a reserved row, then PRE (code 2) to bank 0, then ACT to bank 8 at the same reserved row, then PRE to bank 8. The pair i targets bank i*NUM_BANKS/SEQ_LEN.
- R4: The train on row 0x3FFA moves single-bank mode to all-bank mode (code 1). The final PRE still sees the old mode, and the next command sees the new one.
- R5: In all-bank mode a WR (code 4) raises `bcast_en`, and every non-NOP command selects all banks whose bit 0 equals bit 0 of `cmd_bank` (0x5555 for even banks, 0xAAAA for odd banks).
- R6: The train on row 0x3FFB moves all-bank mode to all-bank-PIM mode (code 2).
- R7: In all-bank-PIM mode every RD (code 3) or WR raises `exec_trig` in the same cycle. ACT, PRE and REF (code 5) do not.
- R8: `io_dis` is high in all-bank-PIM mode and low in the other two modes.
- R9: The train on row 0x3FFC returns either all-bank mode or all-bank-PIM mode to single-bank mode.
- R10: A complete train whose row does not fit the current mode leaves the mode unchanged (for example 0x3FFB or 0x3FFC in single-bank mode, or 0x3FFA in all-bank mode).
- R11: Any non-NOP command that is not the next expected step resets the train. If that command is itself a valid first step (ACT to bank 0 at a reserved row), it starts a new train.
- R12: NOP cycles between the steps of a train do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_type | input | 3 | Command code: 0 NOP, 1 ACT, 2 PRE, 3 RD, 4 WR, 5 REF |
| cmd_bank | input | 4 | Bank address of the command |
| cmd_row | input | 14 | Row address (meaningful with ACT) |
| mode | output | 2 | Current mode: 0 single-bank, 1 all-bank, 2 all-bank-PIM |
| bank_sel | output | 16 | Banks reached by the current command |
| bcast_en | output | 1 | Write is being replicated across the bank set |
| exec_trig | output | 1 | Processing units execute their next instruction |
| io_dis | output | 1 | External data path disabled |

## Verification
The trains are driven in several forms: back to back, spread out by NOP cycles, broken by a read, and restarted midway by a fresh first step. These forms show whether the sequence tracker keeps its position only across idle cycles and whether it restarts on a valid first step. Complete trains are also sent on rows that do not fit the current mode, which catches any wrong or missing entry in the transition table. Ordinary reads, writes and activates are sent in each mode, to even and odd banks. These show the bank fan-out, broadcast, trigger and I/O-disable behaviour of each mode. The cycle of the final precharge is sampled separately from the cycle after it, to confirm when the new mode takes effect.

// File: rtl/pim_mode_pkg.sv
package pim_mode_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'd0,
    MODE_ALL     = 2'd1,
    MODE_ALL_PIM = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    PAT_NONE      = 2'd0,
    PAT_TO_ALL    = 2'd1,
    PAT_TO_PIM    = 2'd2,
    PAT_TO_SINGLE = 2'd3
  } pat_e;

endpackage

// File: rtl/pim_seq_matcher.sv
module pim_seq_matcher
  import pim_mode_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 16,
  parameter int unsigned ROW_W         = 14,
  parameter int unsigned SEQ_LEN       = 2,
  parameter int unsigned ROW_TO_ALL    = 'h3FFA,
  parameter int unsigned ROW_TO_PIM    = 'h3FFB,
  parameter int unsigned ROW_TO_SINGLE = 'h3FFC,
  localparam int unsigned BANK_W       = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd_type,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  output logic              done_o,
  output pat_e              pat_o
);

  localparam int unsigned STEPS  = 2 * SEQ_LEN;
  localparam int unsigned STEP_W = $clog2(STEPS + 1);
  localparam int unsigned STRIDE = NUM_BANKS / SEQ_LEN;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0] step_q, step_d;
  pat_e              pat_q, pat_d;
  pat_e              row_pat;
  logic [BANK_W-1:0] exp_bank;
  logic              is_start;
  logic              done;
  logic              adv_en;

  // classify the row address against the reserved rows
  always_comb begin
    if (cmd_row == ROW_W'(ROW_TO_ALL))         row_pat = PAT_TO_ALL;
    else if (cmd_row == ROW_W'(ROW_TO_PIM))    row_pat = PAT_TO_PIM;
    else if (cmd_row == ROW_W'(ROW_TO_SINGLE)) row_pat = PAT_TO_SINGLE;
    else                                       row_pat = PAT_NONE;
  end

  always_comb begin
    exp_bank = BANK_W'((int'(step_q) >> 1) * STRIDE);
  end

  assign is_start = (cmd_type == CMD_ACT) && (cmd_bank == '0) && (row_pat != PAT_NONE);
  assign adv_en   = (cmd_type != CMD_NOP);

  always_comb begin
    step_d = step_q;
    pat_d  = pat_q;
    done   = 1'b0;
    if (adv_en) begin
      if (!step_q[0]) begin
        if ((cmd_type == CMD_ACT) && (cmd_bank == exp_bank) && (row_pat != PAT_NONE) &&
            ((step_q == '0) || (row_pat == pat_q))) begin
          step_d = step_q + 1'b1;
          if (step_q == '0) pat_d = row_pat;
        end else if (is_start) begin
          step_d = STEP_W'(1);
          pat_d  = row_pat;
        end else begin
          step_d = '0;
          pat_d  = PAT_NONE;
        end
      end else begin
        if ((cmd_type == CMD_PRE) && (cmd_bank == exp_bank)) begin
          if (step_q == LAST_STEP) begin
            done   = 1'b1;
            step_d = '0;
            pat_d  = PAT_NONE;
          end else begin
            step_d = step_q + 1'b1;
          end
        end else if (is_start) begin
          step_d = STEP_W'(1);
          pat_d  = row_pat;
        end else begin
          step_d = '0;
          pat_d  = PAT_NONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      pat_q  <= PAT_NONE;
    end else if (adv_en) begin
      step_q <= step_d;
      pat_q  <= pat_d;
    end
  end

  assign done_o = done;
  assign pat_o  = pat_q;

endmodule

// File: rtl/pim_mode_fsm.sv
module pim_mode_fsm
  import pim_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  done_i,
  input  pat_e  pat_i,
  output mode_e mode_o
);

  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_SINGLE:  if (pat_i == PAT_TO_ALL)    mode_d = MODE_ALL;
      MODE_ALL: begin
        if (pat_i == PAT_TO_PIM)                mode_d = MODE_ALL_PIM;
        else if (pat_i == PAT_TO_SINGLE)        mode_d = MODE_SINGLE;
      end
      MODE_ALL_PIM: if (pat_i == PAT_TO_SINGLE) mode_d = MODE_SINGLE;
      default:                                  mode_d = MODE_SINGLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SINGLE;
    end else if (done_i) begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/pim_bank_fanout.sv
module pim_bank_fanout
  import pim_mode_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 16,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  mode_e                mode_i,
  input  cmd_e                 cmd_type,
  input  logic [BANK_W-1:0]    cmd_bank,
  output logic [NUM_BANKS-1:0] bank_sel_o,
  output logic                 bcast_en_o,
  output logic                 exec_trig_o,
  output logic                 io_dis_o
);

  logic [NUM_BANKS-1:0] one_vec;
  logic [NUM_BANKS-1:0] pair_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic PARITY = 1'(b % 2);
    assign one_vec[b]  = (cmd_bank == BANK_W'(b));
    assign pair_vec[b] = (cmd_bank[0] == PARITY);
  end

  logic is_cmd, is_access;
  assign is_cmd    = (cmd_type != CMD_NOP);
  assign is_access = (cmd_type == CMD_RD) || (cmd_type == CMD_WR);

  always_comb begin
    bank_sel_o  = '0;
    bcast_en_o  = 1'b0;
    exec_trig_o = 1'b0;
    io_dis_o    = (mode_i == MODE_ALL_PIM);
    if (is_cmd) begin
      if (mode_i == MODE_SINGLE) begin
        bank_sel_o = one_vec;
      end else begin
        bank_sel_o = pair_vec;
      end
      bcast_en_o  = (mode_i == MODE_ALL) && (cmd_type == CMD_WR);
      exec_trig_o = (mode_i == MODE_ALL_PIM) && is_access;
    end
  end

endmodule

// File: rtl/pim_mode_ctrl.sv
module pim_mode_ctrl
  import pim_mode_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 16,
  parameter int unsigned ROW_W         = 14,
  parameter int unsigned SEQ_LEN       = 2,
  parameter int unsigned ROW_TO_ALL    = 'h3FFA,
  parameter int unsigned ROW_TO_PIM    = 'h3FFB,
  parameter int unsigned ROW_TO_SINGLE = 'h3FFC,
  localparam int unsigned BANK_W       = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_type,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [ROW_W-1:0]     cmd_row,
  output logic [1:0]           mode,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic                 bcast_en,
  output logic                 exec_trig,
  output logic                 io_dis
);

  cmd_e  cmd_t;
  logic  pat_done;
  pat_e  pat_id;
  mode_e mode_cur;

  assign cmd_t = cmd_e'(cmd_type);

  pim_seq_matcher #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .SEQ_LEN(SEQ_LEN),
    .ROW_TO_ALL(ROW_TO_ALL), .ROW_TO_PIM(ROW_TO_PIM), .ROW_TO_SINGLE(ROW_TO_SINGLE)
  ) u_match (
    .clk(clk), .rst_n(rst_n), .cmd_type(cmd_t), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .done_o(pat_done), .pat_o(pat_id)
  );

  pim_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .done_i(pat_done), .pat_i(pat_id), .mode_o(mode_cur)
  );

  pim_bank_fanout #(.NUM_BANKS(NUM_BANKS)) u_fan (
    .mode_i(mode_cur), .cmd_type(cmd_t), .cmd_bank(cmd_bank),
    .bank_sel_o(bank_sel), .bcast_en_o(bcast_en), .exec_trig_o(exec_trig), .io_dis_o(io_dis)
  );

  assign mode = mode_cur;

endmodule

// File: rtl/pim_mode_ctrl_chk.sv
module pim_mode_ctrl_chk #(
  parameter int unsigned NUM_BANKS = 16,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cmd_type,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic [1:0]           mode,
  input logic [NUM_BANKS-1:0] bank_sel,
  input logic                 bcast_en,
  input logic                 exec_trig,
  input logic                 io_dis
);

  // R4
  mode_moves_on_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> ($past(cmd_type) == 3'd2));

  // R6
  no_skip_to_pim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd0) |-> (mode != 2'd2));

  // R2
  single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd0) && (cmd_type != 3'd0)) |-> ($countones(bank_sel) == 1));

  // R5
  bcast_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_en |-> (($countones(bank_sel) == NUM_BANKS / 2) && (mode == 2'd1)));

  // R7
  trig_only_pim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_trig |-> (io_dis && ((cmd_type == 3'd3) || (cmd_type == 3'd4))));

  // R8
  io_dis_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_dis |-> (mode == 2'd2));

endmodule

bind pim_mode_ctrl pim_mode_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_type(cmd_type), .cmd_bank(cmd_bank), .mode(mode),
  .bank_sel(bank_sel), .bcast_en(bcast_en), .exec_trig(exec_trig), .io_dis(io_dis)
);

// File: tb/pim_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pim_mode_ctrl_tb_top;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, PRE = 3'd2, RD = 3'd3, WR = 3'd4, REF = 3'd5;
  localparam logic [13:0] R_ALL = 14'h3FFA, R_PIM = 14'h3FFB, R_SGL = 14'h3FFC;

  logic        clk;
  logic        rst_n;
  logic [2:0]  cmd_type;
  logic [3:0]  cmd_bank;
  logic [13:0] cmd_row;
  logic [1:0]  mode;
  logic [15:0] bank_sel;
  logic        bcast_en, exec_trig, io_dis;

  int n_chk;
  int n_fail;

  pim_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_type(cmd_type), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .mode(mode), .bank_sel(bank_sel), .bcast_en(bcast_en), .exec_trig(exec_trig), .io_dis(io_dis)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one command at the falling edge; outputs settle 1 ns later
  task automatic cmd(input logic [2:0] t, input logic [3:0] b, input logic [13:0] r);
    @(negedge clk);
    cmd_type = t;
    cmd_bank = b;
    cmd_row  = r;
    #1;
  endtask

  task automatic idle();
    cmd(NOP, 4'd0, 14'd0);
  endtask

  task automatic train(input logic [13:0] r);
    cmd(ACT, 4'd0, r);
    cmd(PRE, 4'd0, 14'd0);
    cmd(ACT, 4'd8, r);
    cmd(PRE, 4'd8, 14'd0);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mode), 32'd0);
    chk("R1 io_dis", 32'(io_dis), 32'd0);
    chk("R1 bcast_en", 32'(bcast_en), 32'd0);
    chk("R1 exec_trig", 32'(exec_trig), 32'd0);
  endtask

  task automatic t_single();
    cmd(WR, 4'd5, 14'd0);
    chk("R2 wr bank_sel", 32'(bank_sel), 32'h0020);
    chk("R2 wr bcast_en", 32'(bcast_en), 32'd0);
    chk("R2 wr exec_trig", 32'(exec_trig), 32'd0);
    cmd(ACT, 4'd12, 14'h0123);
    chk("R2 act bank_sel", 32'(bank_sel), 32'h1000);
    idle();
    chk("R2 nop bank_sel", 32'(bank_sel), 32'h0000);
  endtask

  task automatic t_ignore_single();
    train(R_PIM);
    chk("R10 pim train in single", 32'(mode), 32'd0);
    train(R_SGL);
    chk("R10 exit train in single", 32'(mode), 32'd0);
  endtask

  task automatic t_interrupt();
    cmd(ACT, 4'd0, R_ALL);
    cmd(PRE, 4'd0, 14'd0);
    cmd(RD, 4'd3, 14'd0);
    cmd(ACT, 4'd8, R_ALL);
    cmd(PRE, 4'd8, 14'd0);
    idle();
    chk("R11 broken train", 32'(mode), 32'd0);
    cmd(ACT, 4'd0, R_ALL);
    cmd(PRE, 4'd0, 14'd0);
    cmd(ACT, 4'd8, 14'h0011);
    cmd(PRE, 4'd8, 14'd0);
    idle();
    chk("R11 wrong row midway", 32'(mode), 32'd0);
    // a fresh first step in the middle restarts the train
    cmd(ACT, 4'd0, R_ALL);
    cmd(PRE, 4'd0, 14'd0);
    cmd(ACT, 4'd0, R_ALL);
    cmd(PRE, 4'd0, 14'd0);
    cmd(ACT, 4'd8, R_ALL);
    cmd(PRE, 4'd8, 14'd0);
    idle();
    chk("R11 restart", 32'(mode), 32'd1);
  endtask

  task automatic t_exit_all();
    train(R_SGL);
    chk("R9 all to single", 32'(mode), 32'd0);
  endtask

  task automatic t_enter_all_idle();
    cmd(ACT, 4'd0, R_ALL);
    idle();
    cmd(PRE, 4'd0, 14'd0);
    idle();
    idle();
    cmd(ACT, 4'd8, R_ALL);
    idle();
    cmd(PRE, 4'd8, 14'd0);
    chk("R4 final pre sees old mode", 32'(mode), 32'd0);
    chk("R3 final pre single bank", 32'(bank_sel), 32'h0100);
    cmd(WR, 4'd2, 14'd0);
    chk("R4 next cmd sees all-bank", 32'(mode), 32'd1);
    chk("R12 idle gaps", 32'(bcast_en), 32'd1);
  endtask

  task automatic t_all();
    train(R_ALL);
    chk("R10 all train in all", 32'(mode), 32'd1);
    cmd(WR, 4'd0, 14'd0);
    chk("R5 even bcast mask", 32'(bank_sel), 32'h5555);
    chk("R5 bcast_en", 32'(bcast_en), 32'd1);
    chk("R8 io_dis in all", 32'(io_dis), 32'd0);
    cmd(WR, 4'd3, 14'd0);
    chk("R5 odd bcast mask", 32'(bank_sel), 32'hAAAA);
    cmd(RD, 4'd1, 14'd0);
    chk("R5 rd no bcast", 32'(bcast_en), 32'd0);
    chk("R5 rd no trig", 32'(exec_trig), 32'd0);
  endtask

  task automatic t_pim();
    train(R_PIM);
    chk("R6 all to pim", 32'(mode), 32'd2);
    chk("R8 io_dis in pim", 32'(io_dis), 32'd1);
    cmd(RD, 4'd4, 14'd0);
    chk("R7 rd triggers", 32'(exec_trig), 32'd1);
    cmd(WR, 4'd7, 14'd0);
    chk("R7 wr triggers", 32'(exec_trig), 32'd1);
    chk("R7 wr no bcast", 32'(bcast_en), 32'd0);
    cmd(ACT, 4'd2, 14'h0040);
    chk("R7 act no trigger", 32'(exec_trig), 32'd0);
    cmd(REF, 4'd0, 14'd0);
    chk("R7 ref no trigger", 32'(exec_trig), 32'd0);
    train(R_ALL);
    chk("R10 all train in pim", 32'(mode), 32'd2);
    train(R_SGL);
    chk("R9 pim to single", 32'(mode), 32'd0);
    chk("R8 io_dis after exit", 32'(io_dis), 32'd0);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    cmd_type = NOP;
    cmd_bank = '0;
    cmd_row = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_single();
    t_ignore_single();
    t_interrupt();
    t_exit_all();
    t_enter_all_idle();
    t_all();
    t_pim();
    repeat (2) idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule